// File: doc/BRIEF.md
# ECC-Protected Dual-Clock FIFO

This block is a first-in first-out buffer whose write and read ports run on their own clocks and resets. Every word is encoded with a single-error-correct, double-error-detect code before it enters storage. On the way out the code is checked, any single flipped bit is repaired, and the block reports whether a repair was made or the word could not be recovered. It also gives the storage address of the word whose check result is shown.

The port clocks may be unrelated. In that case each pointer crosses to the other side as gray code through two flip-flops, so a flag may react late but never claims room or data that does not exist. A static mode input tells the block that both ports share one clock. It then compares the pointers directly, and the flags follow the other side on the next edge. A test input XORs a mask into the stored codeword, so the error paths can be exercised. An optional output register holds the read results. It has its own enable, and a clear that resets only that register.

Top module: `secded_afifo`

## Requirements
- R1: After both resets, is_empty and near_empty are 1, is_full, near_full, overflow and underflow are 0, and rd_data, err_fixed, err_fatal and err_addr are 0.
- R2: Words come out in the order they were accepted, and at most 2^AW words are held. With the output register enabled, the data of a read requested at edge k is on rd_data after edge k+1.
- R3: is_full is 1 exactly when 2^AW words are held, and is_empty is 1 exactly when none are held. In shared-clock mode both flags reflect a write or a read on the next edge.
- R4: near_full is 1 when the fill level is at least 2^AW − NEAR_FULL, and near_empty is 1 when the fill level is at most NEAR_EMPTY.
- R5: A write request while is_full is 1 raises overflow for one cycle after that edge. The word is not stored and the fill level does not change.
- R6: A read request while is_empty is 1 raises underflow for one cycle. rd_data and the read pointer do not change.
- R7: If flip_mask has exactly one bit set during a write (flipping that bit of the 40-bit stored word, whichever of the 40 it is), the word reads back with correct data, err_fixed=1 and err_fatal=0.
- R8: If flip_mask has two bits set during a write, the word reads back with err_fatal=1 and err_fixed=0.
- R9: err_addr shows the storage slot of the word on rd_data. That slot is the count of reads since reset, modulo 2^AW.
- R10: With the output register present, oreg_en=0 holds rd_data and the error outputs. oreg_clr=1 sets rd_data, err_fixed, err_fatal and err_addr to 0 on the next edge.
- R11: With same_clk=0, a write is seen by is_empty no earlier than two read-clock edges later and no later than three. A read frees is_full with the same latency on the write side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_req | input | 1 | Write request |
| wr_data | input | 32 | Word to store |
| flip_mask | input | 40 | Bits XORed into the stored codeword (test injection) |
| is_full | output | 1 | No room left |
| near_full | output | 1 | Fill level at or above the high threshold |
| overflow | output | 1 | One-cycle pulse after a write refused for lack of room |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_req | input | 1 | Read request |
| oreg_en | input | 1 | Output register load enable |
| oreg_clr | input | 1 | Synchronous clear of the output register only |
| same_clk | input | 1 | Static: 1 when both ports use one clock |
| rd_data | output | 32 | Corrected read word |
| is_empty | output | 1 | Nothing to read |
| near_empty | output | 1 | Fill level at or below the low threshold |
| underflow | output | 1 | One-cycle pulse after a read refused because the FIFO is empty |
| err_fixed | output | 1 | Single-bit error was corrected in this word |
| err_fatal | output | 1 | Uncorrectable double-bit error in this word |
| err_addr | output | AW | Storage slot of the word shown |

## Verification
The bench sweeps a single injected flip across all 40 stored bit positions, including the overall parity bit and the spare check bit. A decoder with a misplaced check bit would corrupt the data or report a double error for some of them. Paired flips must give err_fatal, because a mis-built parity term would instead "repair" a wrong bit. Writes and reads into a full or empty FIFO must leave the order intact, so a pointer that advanced anyway would show up as a skipped or repeated word. In unshared-clock mode the bench checks that is_empty and is_full stay pessimistic for the synchronizer delay and then clear, which catches a missing or collapsed synchronizer stage.

// File: rtl/secded_afifo.sv
module secded_afifo #(
  parameter int AW         = 11,
  parameter int NEAR_FULL  = 16,
  parameter int NEAR_EMPTY = 16,
  parameter bit OUT_REG    = 1'b1
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_req,
  input  logic [31:0]   wr_data,
  input  logic [39:0]   flip_mask,
  output logic          is_full,
  output logic          near_full,
  output logic          overflow,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_req,
  input  logic          oreg_en,
  input  logic          oreg_clr,
  input  logic          same_clk,
  output logic [31:0]   rd_data,
  output logic          is_empty,
  output logic          near_empty,
  output logic          underflow,
  output logic          err_fixed,
  output logic          err_fatal,
  output logic [AW-1:0] err_addr
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = 40;

  function automatic logic [CW-1:0] encode(input logic [31:0] d);
    logic [CW-1:0] c;
    logic p;
    int j;
    c = '0;
    j = 0;
    for (int i = 3; i < 39; i++)
      if ((i & (i - 1)) != 0) begin
        c[i[5:0]] = d[j[4:0]];
        j = j + 1;
      end
    for (int k = 0; k < 6; k++) begin
      p = 1'b0;
      for (int i = 1; i < CW; i++)
        if (((i >> k) & 1) != 0 && i != (1 << k)) p = p ^ c[i[5:0]];
      c[6'(1 << k)] = p;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [5:0] syndrome(input logic [CW-1:0] c);
    logic [5:0] s;
    s = '0;
    for (int k = 0; k < 6; k++)
      for (int i = 1; i < CW; i++)
        if (((i >> k) & 1) != 0) s[k[2:0]] = s[k[2:0]] ^ c[i[5:0]];
    return s;
  endfunction

  function automatic logic [31:0] extract(input logic [CW-1:0] c);
    logic [31:0] d;
    int j;
    d = '0;
    j = 0;
    for (int i = 3; i < 39; i++)
      if ((i & (i - 1)) != 0) begin
        d[j[4:0]] = c[i[5:0]];
        j = j + 1;
      end
    return d;
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b = g;
    for (int i = 1; i <= AW; i++) b = b ^ (g >> i);
    return b;
  endfunction

  logic [CW-1:0] mem [DEPTH];
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   wg1, wg2, rg1, rg2;
  logic [CW-1:0] q;
  logic [AW-1:0] qaddr;

  wire [AW:0] rbin_w = same_clk ? rbin : g2b(rg2);
  wire [AW:0] wbin_r = same_clk ? wbin : g2b(wg2);
  wire [AW:0] wfill  = wbin - rbin_w;
  wire [AW:0] rfill  = wbin_r - rbin;
  wire [AW:0] wnext  = wbin + 1'b1;
  wire [AW:0] rnext  = rbin + 1'b1;

  assign is_full    = wfill == (AW+1)'(DEPTH);
  assign near_full  = int'(wfill) >= DEPTH - NEAR_FULL;
  assign is_empty   = rfill == '0;
  assign near_empty = int'(rfill) <= NEAR_EMPTY;

  wire wr_ok = wr_req & ~is_full;
  wire rd_ok = rd_req & ~is_empty;

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      wbin <= '0; wgray <= '0; overflow <= 1'b0; rg1 <= '0; rg2 <= '0;
    end else begin
      overflow <= wr_req & is_full;
      rg1 <= rgray;
      rg2 <= rg1;
      if (wr_ok) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end
  end

  always_ff @(posedge wr_clk)
    if (wr_ok) mem[wbin[AW-1:0]] <= encode(wr_data) ^ flip_mask;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rbin <= '0; rgray <= '0; underflow <= 1'b0; wg1 <= '0; wg2 <= '0;
      q <= '0; qaddr <= '0;
    end else begin
      underflow <= rd_req & is_empty;
      wg1 <= wgray;
      wg2 <= wg1;
      if (rd_ok) begin
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
        q     <= mem[rbin[AW-1:0]];
        qaddr <= rbin[AW-1:0];
      end
    end
  end

  logic [5:0]    syn;
  logic          par;
  logic [CW-1:0] fixed;
  always_comb begin
    syn   = syndrome(q);
    par   = ^q;
    fixed = q;
    if (par && int'(syn) < CW) fixed[syn] = ~q[syn];
  end

  wire [31:0] dec_data  = extract(fixed);
  wire        dec_fixed = par;
  wire        dec_fatal = ~par & (syn != '0);

  logic oreg_on;
  assign oreg_on = OUT_REG;

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge rd_clk) begin
      if (rd_rst | oreg_clr) begin
        rd_data <= '0; err_fixed <= 1'b0; err_fatal <= 1'b0; err_addr <= '0;
      end else if (oreg_en) begin
        rd_data <= dec_data; err_fixed <= dec_fixed;
        err_fatal <= dec_fatal; err_addr <= qaddr;
      end
    end
  end else begin : g_direct
    assign rd_data   = dec_data;
    assign err_fixed = dec_fixed;
    assign err_fatal = dec_fatal;
    assign err_addr  = qaddr;
  end
endmodule

// File: rtl/secded_afifo_chk.sv
module secded_afifo_chk (
  input logic        wr_clk,
  input logic        wr_rst,
  input logic        wr_req,
  input logic        is_full,
  input logic        near_full,
  input logic        overflow,
  input logic        rd_clk,
  input logic        rd_rst,
  input logic        rd_req,
  input logic        is_empty,
  input logic        near_empty,
  input logic        underflow,
  input logic        err_fixed,
  input logic        err_fatal,
  input logic        same_clk,
  input logic        oreg_on,
  input logic        oreg_en,
  input logic        oreg_clr,
  input logic [31:0] rd_data
);
  AST_OVERFLOW_PULSE: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_req && is_full |=> overflow); // R5
  AST_UNDERFLOW_PULSE: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_req && is_empty |=> underflow); // R6
  AST_ERR_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(err_fixed && err_fatal)); // R8
  AST_FULL_NEAR: assert property (@(posedge wr_clk) disable iff (wr_rst)
    is_full |-> near_full); // R4
  AST_EMPTY_NEAR: assert property (@(posedge rd_clk) disable iff (rd_rst)
    is_empty |-> near_empty); // R4
  AST_NOT_BOTH: assert property (@(posedge wr_clk) disable iff (wr_rst || rd_rst)
    same_clk |-> !(is_full && is_empty)); // R3
  AST_OREG_CLEAR: assert property (@(posedge rd_clk) disable iff (rd_rst)
    oreg_on && oreg_clr |=> rd_data == '0 && !err_fixed && !err_fatal); // R10
  AST_OREG_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
    oreg_on && !oreg_en && !oreg_clr |=> $stable(rd_data)); // R10
endmodule

bind secded_afifo secded_afifo_chk u_chk (.*);

// File: tb/test_secded_afifo.sv
module test_secded_afifo;
  localparam int AW = 4, DEPTH = 16, NF = 3, NE = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic wr_rst, wr_req, rd_rst, rd_req, oreg_en, oreg_clr, same_clk;
  logic [31:0] wr_data, rd_data;
  logic [39:0] flip_mask;
  logic is_full, near_full, overflow, is_empty, near_empty, underflow, err_fixed, err_fatal;
  logic [AW-1:0] err_addr;

  secded_afifo #(.AW(AW), .NEAR_FULL(NF), .NEAR_EMPTY(NE), .OUT_REG(1'b1)) i_secded_afifo (
    .wr_clk(clk), .wr_rst(wr_rst), .wr_req(wr_req), .wr_data(wr_data), .flip_mask(flip_mask),
    .is_full(is_full), .near_full(near_full), .overflow(overflow),
    .rd_clk(clk), .rd_rst(rd_rst), .rd_req(rd_req), .oreg_en(oreg_en), .oreg_clr(oreg_clr),
    .same_clk(same_clk), .rd_data(rd_data), .is_empty(is_empty), .near_empty(near_empty),
    .underflow(underflow), .err_fixed(err_fixed), .err_fatal(err_fatal), .err_addr(err_addr));

  int n_chk = 0, n_bad = 0, rcount = 0, seq = 0;
  bit done = 0;
  logic [31:0] model[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat();
    seq++;
    return (32'h9E3779B9 * seq) ^ (seq << 7);
  endfunction

  task automatic flags(input int n);
    check("R3 full", is_full, n == DEPTH);
    check("R3 empty", is_empty, n == 0);
    check("R4 near_full", near_full, n >= DEPTH - NF);
    check("R4 near_empty", near_empty, n <= NE);
  endtask

  task automatic push(input logic [31:0] d, input logic [39:0] m);
    wr_req = 1; wr_data = d; flip_mask = m;
    @(negedge clk);
    wr_req = 0; flip_mask = '0;
    if (model.size() < DEPTH) model.push_back(d);
  endtask

  task automatic pop(input bit ef, input bit ed, input bit cd);
    logic [31:0] e;
    e = model.pop_front();
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    @(negedge clk);
    if (cd) check("R2 data", rd_data, e);
    check("R7 fixed flag", err_fixed, ef);
    check("R8 fatal flag", err_fatal, ed);
    check("R9 address", err_addr, rcount % DEPTH);
    rcount++;
  endtask

  task automatic do_reset(input bit sc);
    same_clk = sc; wr_rst = 1; rd_rst = 1;
    repeat (3) @(negedge clk);
    wr_rst = 0; rd_rst = 0;
    model.delete(); rcount = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, keep;
    wr_req = 0; rd_req = 0; wr_data = '0; flip_mask = '0;
    oreg_en = 1; oreg_clr = 0;
    do_reset(1'b1);
    // R1
    flags(0);
    check("R1 overflow", overflow, 0);
    check("R1 underflow", underflow, 0);
    check("R1 rd_data", rd_data, 0);
    check("R1 err flags", {err_fixed, err_fatal}, 0);
    check("R1 err_addr", err_addr, 0);

    for (int i = 0; i < DEPTH; i++) begin
      push(pat(), '0);
      flags(model.size());
    end
    // R5
    push(32'hDEAD_BEEF, '0);
    check("R5 overflow pulse", overflow, 1);
    check("R5 still full", is_full, 1);
    @(negedge clk);
    check("R5 pulse ends", overflow, 0);
    for (int i = 0; i < DEPTH; i++) begin
      pop(0, 0, 1);
      flags(model.size());
    end
    // R6
    keep = rd_data;
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    check("R6 underflow pulse", underflow, 1);
    @(negedge clk);
    check("R6 pulse ends", underflow, 0);
    check("R6 data held", rd_data, keep);
    check("R6 still empty", is_empty, 1);

    // R2 wrap-around with varying fill
    for (int i = 0; i < 48; i++) begin
      push(pat(), '0);
      if (i % 4 != 0) pop(0, 0, 1);
      flags(model.size());
    end
    while (model.size() > 0) pop(0, 0, 1);

    // R7 every single-bit position
    for (int bpos = 0; bpos < 40; bpos++) begin
      push(pat(), 40'(1) << bpos);
      pop(1, 0, 1);
    end
    // R8 bit pairs
    for (int bpos = 0; bpos < 40; bpos++) begin
      push(pat(), (40'(1) << bpos) | (40'(1) << ((bpos + 13) % 40)));
      pop(0, 1, 0);
    end

    // R10 output register
    a = pat(); b = pat();
    push(a, '0); push(b, '0);
    pop(0, 0, 1);
    oreg_en = 0;
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
    @(negedge clk);
    void'(model.pop_front());
    rcount++;
    check("R10 hold data", rd_data, a);
    oreg_en = 1;
    @(negedge clk);
    check("R10 load after enable", rd_data, b);
    push(pat(), 40'h8);
    pop(1, 0, 1);
    oreg_clr = 1;
    @(negedge clk);
    oreg_clr = 0;
    check("R10 clear data", rd_data, 0);
    check("R10 clear flag", err_fixed, 0);
    check("R10 clear addr", err_addr, 0);
    @(negedge clk);

    // R11 separate-clock mode
    do_reset(1'b0);
    push(pat(), '0);
    check("R11 empty stale", is_empty, 1);
    @(negedge clk);
    check("R11 empty stale 2", is_empty, 1);
    @(negedge clk);
    check("R11 empty clears", is_empty, 0);
    for (int i = 1; i < DEPTH; i++) push(pat(), '0);
    check("R11 full immediate", is_full, 1);
    pop(0, 0, 1);
    check("R11 full stale", is_full, 1);
    @(negedge clk);
    check("R11 full clears", is_full, 0);
    while (model.size() > 0) pop(0, 0, 1);
    repeat (3) @(negedge clk);
    check("R11 empty at end", is_empty, 1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule